// File: doc/BRIEF.md
# Serial CRC-8 Accumulator with LSB-First Shift-Out

This block keeps a running 8-bit integrity check for traffic on a single-wire bus. It uses the generator x^8 + x^5 + x^4 + 1. Data reaches it least significant bit first, so the register shifts right and applies the generator in reflected form, 0x8C. There are two ways to feed it. A single-bit stream port handles one bit per transfer. A byte port accepts a whole byte and then works through its eight bits on its own, one per clock. The controlling logic decides which bus bytes go through the accumulator. The block itself only does the arithmetic and the serialisation.

When the controller has to send the check value, it strobes a shift-out request once per bus bit. The register leaves least significant bit first. It also shifts right as each bit leaves, so after the eighth strobe it holds zero and is ready for the next computation. A one-cycle done pulse marks the end of the shift-out. A clear input sets the register back to zero at any time and takes priority over everything else.

Both data inputs use valid/ready handshakes. A transfer takes place on a rising clock edge where valid and ready are both high. A source holding valid while ready is low keeps its data pending, and the block does not look at it. Ready depends on the clear input and on the shift-out request in the same cycle. It does not depend on either valid.

Top module: `crc8r_acc`

## Requirements
- R1: Right after reset, `crc_o` is 0x00, `busy_o` and `done_o` are low, and both ready outputs are high.
- R2: When a single-bit transfer is accepted, the register update is as follows. If `crc_o[0]` XOR the bit is 1, the register becomes (register >> 1) XOR 0x8C. Otherwise it becomes register >> 1. The new value shows on `crc_o` after that edge.
- R3: An accepted byte raises `busy_o` for exactly 8 cycles. During those cycles its bits are applied bit 0 first, each with the R2 rule. Once `busy_o` falls, `crc_o` holds the updated check value.
- R4: While `busy_o` is high, both ready outputs are low. Bits, bytes and valids offered during that time have no effect on `crc_o`.
- R5: Each shift-out strobe taken while `busy_o` is low does three things. It puts the current `crc_o[0]` on `shout_bit_o` after the edge, shifts the register right by one and fills bit 7 with zero. The bits therefore leave least significant first.
- R6: The eighth strobe of a shift-out leaves `crc_o` at 0x00. It also raises `done_o` for exactly one cycle.
- R7: `clr_i` takes priority over all other activity in the same cycle. After that edge `crc_o` is 0x00, `busy_o` is low and `done_o` is low.
- R8: A shift-out strobe issued while `busy_o` is high is ignored. It does not change `crc_o` and it does not count toward the eight strobes.
- R9: A bit and a byte accepted in the same cycle are both applied. The bit goes first, in that cycle, and the byte's eight bits follow.
- R10: Start from 0x00, feed any byte stream, then feed the resulting check byte. The register ends at 0x00.
- R11: Both ready outputs are low in any cycle where `shout_req_i` or `clr_i` is high. Ready also stays low while a shift-out is part-way through, which means after its first strobe and before `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the register and sequencers |
| bit_valid_i | input | 1 | Single-bit transfer offered |
| bit_data_i | input | 1 | Bit value of the offered transfer |
| bit_ready_o | output | 1 | Single-bit port can accept |
| byte_valid_i | input | 1 | Byte transfer offered |
| byte_data_i | input | 8 | Byte value, bit 0 is applied first |
| byte_ready_o | output | 1 | Byte port can accept |
| shout_req_i | input | 1 | Strobe for one bit of shift-out |
| shout_bit_o | output | 1 | Most recently shifted-out bit |
| done_o | output | 1 | One-cycle pulse after the eighth shift-out bit |
| busy_o | output | 1 | A byte's bits are being applied |
| crc_o | output | 8 | Current register value |

## Verification
The bench drives inputs on the falling edge and reads outputs on the next falling edge. Each result is checked in the exact cycle it becomes due. A single bit and each shift-out bit are checked one cycle after acceptance. `done_o` and the zeroed register are checked one cycle after the eighth strobe. For a byte, `busy_o` is sampled high on each of the eight falling edges that follow the acceptance edge, and `crc_o` is checked on the ninth, when `busy_o` has fallen. Stray valids and strobes placed inside the busy window can only have been ignored if that final value matches the bench's reference, and ready is read combinationally shortly after a request or a clear is raised.

// File: rtl/crc8r_pkg.sv
package crc8r_pkg;
  localparam int unsigned CRC_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'h8C;
  typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/crc8r_bit_step.sv
// One reflected LFSR step: shift right, fold in the generator when the
// outgoing bit differs from the incoming data bit.
module crc8r_bit_step #(
  parameter int unsigned W = crc8r_pkg::CRC_W,
  parameter logic [W-1:0] POLY = crc8r_pkg::CRC_POLY_REFL
) (
  input  logic [W-1:0] cur_i,
  input  logic         din_i,
  output logic [W-1:0] nxt_o
);
  logic fb;
  assign fb = cur_i[0] ^ din_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign nxt_o[i] = fb & POLY[i];
    end else begin : g_low
      assign nxt_o[i] = cur_i[i+1] ^ (fb & POLY[i]);
    end
  end
endmodule

// File: rtl/crc8r_byte_feed.sv
// Holds an accepted byte and presents one bit per cycle, LSB first.
module crc8r_byte_feed #(
  parameter int unsigned W = crc8r_pkg::CRC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         busy_o,
  output logic         bit_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      cnt    <= '0;
      busy_o <= 1'b0;
    end else if (clr_i) begin
      sr     <= '0;
      cnt    <= '0;
      busy_o <= 1'b0;
    end else if (busy_o) begin
      sr <= sr >> 1;
      if (cnt == LAST) begin
        cnt    <= '0;
        busy_o <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (load_i) begin
      sr     <= data_i;
      cnt    <= '0;
      busy_o <= 1'b1;
    end
  end

  assign bit_o = sr[0];

  // R3: a load from idle opens the busy window
  a_r3_busy_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !busy_o && !clr_i) |=> busy_o);
  // R3: the window closes after the last bit
  a_r3_busy_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cnt == LAST && !clr_i) |=> !busy_o);
endmodule

// File: rtl/crc8r_shout_ctl.sv
// Counts shift-out strobes, registers the outgoing bit, pulses done.
module crc8r_shout_ctl #(
  parameter int unsigned W = crc8r_pkg::CRC_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic take_i,
  input  logic lsb_i,
  output logic active_o,
  output logic last_o,
  output logic bit_o,
  output logic done_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;

  assign last_o = take_i && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      active_o <= 1'b0;
      bit_o    <= 1'b0;
      done_o   <= 1'b0;
    end else if (clr_i) begin
      cnt      <= '0;
      active_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (take_i) begin
        bit_o <= lsb_i;
        if (cnt == LAST) begin
          cnt      <= '0;
          active_o <= 1'b0;
          done_o   <= 1'b1;
        end else begin
          cnt      <= cnt + 1'b1;
          active_o <= 1'b1;
        end
      end
    end
  end

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5: the emitted bit is the register LSB seen at the strobe
  a_r5_bit_source: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !clr_i) |=> (bit_o == $past(lsb_i)));
endmodule

// File: rtl/crc8r_acc.sv
module crc8r_acc #(
  parameter int unsigned W = crc8r_pkg::CRC_W,
  parameter logic [W-1:0] POLY = crc8r_pkg::CRC_POLY_REFL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         bit_valid_i,
  input  logic         bit_data_i,
  output logic         bit_ready_o,
  input  logic         byte_valid_i,
  input  logic [W-1:0] byte_data_i,
  output logic         byte_ready_o,
  input  logic         shout_req_i,
  output logic         shout_bit_o,
  output logic         done_o,
  output logic         busy_o,
  output logic [W-1:0] crc_o
);
  logic         feed_busy, feed_bit;
  logic         sh_active, sh_last, sh_take;
  logic         idle, bit_acc, byte_acc;
  logic         step_en, step_din;
  logic [W-1:0] step_nxt;

  assign idle         = !feed_busy && !sh_active && !shout_req_i && !clr_i;
  assign bit_ready_o  = idle;
  assign byte_ready_o = idle;
  assign bit_acc      = bit_valid_i && idle;
  assign byte_acc     = byte_valid_i && idle;
  assign sh_take      = shout_req_i && !feed_busy && !clr_i;
  assign step_en      = feed_busy || bit_acc;
  assign step_din     = feed_busy ? feed_bit : bit_data_i;
  assign busy_o       = feed_busy;

  crc8r_bit_step #(.W(W), .POLY(POLY)) u_step (
    .cur_i (crc_o),
    .din_i (step_din),
    .nxt_o (step_nxt)
  );

  crc8r_byte_feed #(.W(W)) u_feed (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .load_i (byte_acc),
    .data_i (byte_data_i),
    .busy_o (feed_busy),
    .bit_o  (feed_bit)
  );

  crc8r_shout_ctl #(.W(W)) u_shout (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_i),
    .take_i   (sh_take),
    .lsb_i    (crc_o[0]),
    .active_o (sh_active),
    .last_o   (sh_last),
    .bit_o    (shout_bit_o),
    .done_o   (done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_o <= '0;
    end else if (clr_i) begin
      crc_o <= '0;
    end else if (sh_take) begin
      crc_o <= sh_last ? '0 : (crc_o >> 1);
    end else if (step_en) begin
      crc_o <= step_nxt;
    end
  end

  // R7: clear wins over everything in the same cycle
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (crc_o == '0 && !busy_o && !done_o));
  // R4: no handshake accepted while a byte is in flight
  a_r4_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!bit_ready_o && !byte_ready_o));
  // R6: done coincides with an empty register
  a_r6_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (crc_o == '0));
  // R8: a strobe during a byte leaves the shift-out idle
  a_r8_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && shout_req_i && !sh_active) |=> !done_o);
  // R11: a request in the cycle holds both ports off
  a_r11_req_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    shout_req_i |-> (!bit_ready_o && !byte_ready_o));
endmodule

// File: tb/sim_crc8r_acc.sv
module sim_crc8r_acc;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_i = 1'b0;
  logic       bit_valid_i = 1'b0;
  logic       bit_data_i = 1'b0;
  logic       bit_ready_o;
  logic       byte_valid_i = 1'b0;
  logic [7:0] byte_data_i = 8'h00;
  logic       byte_ready_o;
  logic       shout_req_i = 1'b0;
  logic       shout_bit_o;
  logic       done_o;
  logic       busy_o;
  logic [7:0] crc_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_crc = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc8r_acc u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .bit_valid_i(bit_valid_i), .bit_data_i(bit_data_i), .bit_ready_o(bit_ready_o),
    .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i), .byte_ready_o(byte_ready_o),
    .shout_req_i(shout_req_i), .shout_bit_o(shout_bit_o), .done_o(done_o),
    .busy_o(busy_o), .crc_o(crc_o)
  );

  function automatic logic [7:0] ref_bit(logic [7:0] c, logic b);
    if (c[0] ^ b) return (c >> 1) ^ 8'h8C;
    return c >> 1;
  endfunction

  function automatic logic [7:0] ref_byte(logic [7:0] c, logic [7:0] d);
    logic [7:0] r = c;
    for (int i = 0; i < 8; i++) r = ref_bit(r, d[i]);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    bit_valid_i = 1'b1;
    bit_data_i  = b;
    @(negedge clk);
    bit_valid_i = 1'b0;
    exp_crc = ref_bit(exp_crc, b);
    check(crc_o == exp_crc, "R2 bit step", crc_o, exp_crc);
  endtask

  // inj: offer stray bits, bytes and strobes inside the busy window
  task automatic send_byte(input logic [7:0] d, input bit inj);
    byte_valid_i = 1'b1;
    byte_data_i  = d;
    @(negedge clk);
    byte_valid_i = 1'b0;
    exp_crc = ref_byte(exp_crc, d);
    for (int k = 0; k < 8; k++) begin
      check(busy_o == 1'b1, "R3 busy window", busy_o, 1);
      if (inj) begin
        check(!bit_ready_o && !byte_ready_o, "R4 ready low", bit_ready_o, 0);
        bit_valid_i  = 1'($urandom);
        bit_data_i   = 1'($urandom);
        byte_valid_i = 1'b1;
        byte_data_i  = 8'($urandom);
        shout_req_i  = (k % 3 == 1);
      end
      @(negedge clk);
      check(done_o == 1'b0, "R8 no done", done_o, 0);
    end
    bit_valid_i  = 1'b0;
    byte_valid_i = 1'b0;
    shout_req_i  = 1'b0;
    check(busy_o == 1'b0, "R3 busy end", busy_o, 0);
    check(crc_o == exp_crc, "R3 R4 R8 byte result", crc_o, exp_crc);
  endtask

  task automatic shout_all();
    logic [7:0] e = exp_crc;
    for (int i = 0; i < 8; i++) begin
      if ($urandom % 3 == 0) @(negedge clk);
      shout_req_i = 1'b1;
      #1;
      check(!bit_ready_o && !byte_ready_o, "R11 ready low on req", bit_ready_o, 0);
      @(negedge clk);
      shout_req_i = 1'b0;
      check(shout_bit_o == e[i], "R5 shift bit", shout_bit_o, e[i]);
      if (i < 7) begin
        check(crc_o == (e >> (i + 1)), "R5 shift reg", crc_o, e >> (i + 1));
        check(done_o == 1'b0, "R6 early done", done_o, 0);
        check(!bit_ready_o, "R11 ready low mid shift", bit_ready_o, 0);
      end else begin
        check(done_o == 1'b1, "R6 done", done_o, 1);
        check(crc_o == 8'h00, "R6 cleared", crc_o, 0);
      end
    end
    @(negedge clk);
    check(done_o == 1'b0, "R6 done one cycle", done_o, 0);
    exp_crc = 8'h00;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] d0;
    logic b0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(crc_o == 8'h00 && !busy_o && !done_o, "R1 reset state", crc_o, 0);
    check(bit_ready_o && byte_ready_o, "R1 ready", bit_ready_o, 1);

    // R2 directed bits, including feedback on and off
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b1);
    for (int i = 0; i < 12; i++) send_bit(1'($urandom));

    // R3 R4 R8 bytes, directed edges then random
    send_byte(8'h00, 1'b0);
    send_byte(8'hFF, 1'b1);
    for (int i = 0; i < 20; i++) send_byte(8'($urandom), 1'($urandom));

    // R5 R6 R11 shift-out
    shout_all();
    check(bit_ready_o && byte_ready_o, "R11 ready after done", bit_ready_o, 1);

    // R10 residue after own check byte
    for (int t = 0; t < 6; t++) begin
      int n = 1 + ($urandom % 6);
      for (int j = 0; j < n; j++) send_byte(8'($urandom), 1'b0);
      d0 = exp_crc;
      send_byte(d0, 1'b0);
      check(crc_o == 8'h00, "R10 residue zero", crc_o, 0);
      exp_crc = 8'h00;
    end

    // R9 bit and byte together
    b0 = 1'b1;
    d0 = 8'hA5;
    bit_valid_i  = 1'b1;
    bit_data_i   = b0;
    byte_valid_i = 1'b1;
    byte_data_i  = d0;
    @(negedge clk);
    bit_valid_i  = 1'b0;
    byte_valid_i = 1'b0;
    repeat (8) @(negedge clk);
    exp_crc = ref_byte(ref_bit(exp_crc, b0), d0);
    check(crc_o == exp_crc, "R9 bit before byte", crc_o, exp_crc);
    shout_all();

    // R7 clear in the middle of a byte with a bit offered
    send_bit(1'b1);
    byte_valid_i = 1'b1;
    byte_data_i  = 8'h3C;
    @(negedge clk);
    byte_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    clr_i = 1'b1;
    bit_valid_i = 1'b1;
    shout_req_i = 1'b1;
    #1;
    check(!bit_ready_o && !byte_ready_o, "R11 ready low on clear", bit_ready_o, 0);
    @(negedge clk);
    clr_i = 1'b0;
    bit_valid_i = 1'b0;
    shout_req_i = 1'b0;
    check(crc_o == 8'h00 && !busy_o && !done_o, "R7 clear priority", crc_o, 0);
    exp_crc = 8'h00;

    // R7 clear during a shift-out restarts the count
    send_byte(8'h5A, 1'b0);
    shout_req_i = 1'b1;
    repeat (3) @(negedge clk);
    shout_req_i = 1'b0;
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    check(crc_o == 8'h00 && !done_o, "R7 clear in shift", crc_o, 0);
    exp_crc = 8'h00;
    send_byte(8'hC3, 1'b0);
    shout_all();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule